// File: doc/BRIEF.md
# Key-protected windowed watchdog timer

This block is a system watchdog. A 12-bit counter counts down once every 128 pulses of a slow-clock tick. Software has to restart it in time, or the block raises a fault. Software talks to it through three 32-bit registers: a control word, a mode word and a status word. A restart counts only if it carries the 8-bit password. A restart that arrives while the counter is still above a programmable window threshold counts as an error and does not reload the counter.

The mode word sets the reload value, the window threshold, which fault outputs are driven, a disable bit, and whether the debug-halt and idle inputs stop counting. The mode word accepts exactly one write after reset, and that write loads the counter at once. Any fault, whether an underflow or a window violation, sets a status flag. A set flag drives the interrupt request and/or the reset request, as enabled. Reading the status word clears both flags. The oscillator, the reset controller and the interrupt controller lie outside the block; it only produces the two request levels.

Top module: `wdog_keyed`

## Requirements
- R1: The counter steps down once per 128 cycles in which `slow_tick` is high. With reload value N (N ≥ 1) and `slow_tick` held high, an underflow is flagged on the N*128-th clock edge after the edge that loaded the counter.
- R2: A write to address 0 restarts the counter only if bit 0 is 1 and bits 31:24 equal 0xA5. A write with any other password, or with bit 0 clear, changes nothing.
- R3: Field positions in the mode word (address 1) are: 11:0 reload, 12 interrupt enable, 13 reset enable, 15 disable, 27:16 window threshold, 28 debug-halt gating, 29 idle gating. A read of address 1 returns the accepted mode word, with the unused bits zero.
- R4: After reset the mode word reads 0x0FFF2FFF (reload 0xFFF, threshold 0xFFF, reset enable set, all other bits clear). The status word reads 0, and both request outputs are low.
- R5: Only the first mode write after reset is accepted. Later mode writes change neither the mode word nor the counter.
- R6: The accepted mode write loads the counter with the new reload value on its own clock edge and restarts the 128-tick divider.
- R7: A valid restart while the counter is above the threshold sets the error flag (status bit 1) and leaves the counter running. A valid restart at or below the threshold reloads the counter and the divider.
- R8: A step while the counter is 1 (or 0) sets the underflow flag (status bit 0) and reloads the counter, so underflows repeat every N*128 ticks.
- R9: `fault_irq` is high while a flag is set and interrupt enable is 1. `reset_req` is high while a flag is set and reset enable is 1.
- R10: A read of address 2 returns the flags in bits 1:0 and clears them on that edge.
- R11: With the disable bit set, the counter is frozen, and neither a restart nor time raises any flag.
- R12: While `dbg_halt` (or `idle_in`) is high, counting stops only if the matching gating bit is set. Otherwise the input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| dbg_halt | input | 1 | Core is in debug state |
| idle_in | input | 1 | Core is in idle state |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `addr` |
| fault_irq | output | 1 | Interrupt request level |
| reset_req | output | 1 | Reset request level |

## Verification
Register writes and the status-read clear take effect on the clock edge that samples the strobe. Read data is combinational and is sampled while the strobe is still high. An underflow appears on the request outputs exactly N*128 edges after the edge that loaded the counter: the divider and the flag each add no register stage beyond that edge. Each scenario therefore counts edges from its own write edge. It samples one edge before the due edge, where the output must still be low, and then on the due edge, where it must be high. The bad-password, second-mode-write, disable and ungated-input scenarios prove they had no effect by showing that the underflow stays at that same edge, or that it never comes.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int KEY_W  = 8;
    localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd2;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic             irq_en;
        logic             rst_en;
        logic             disable_wd;
        logic             dbg_hold;
        logic             idle_hold;
    } mode_t;

    localparam mode_t MODE_RESET = '{
        reload: 12'hFFF, delta: 12'hFFF, irq_en: 1'b0, rst_en: 1'b1,
        disable_wd: 1'b0, dbg_hold: 1'b0, idle_hold: 1'b0
    };

    function automatic mode_t unpack_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.reload     = w[11:0];
        m.irq_en     = w[12];
        m.rst_en     = w[13];
        m.disable_wd = w[15];
        m.delta      = w[27:16];
        m.dbg_hold   = w[28];
        m.idle_hold  = w[29];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[11:0]  = m.reload;
        w[12]    = m.irq_en;
        w[13]    = m.rst_en;
        w[15]    = m.disable_wd;
        w[27:16] = m.delta;
        w[28]    = m.dbg_hold;
        w[29]    = m.idle_hold;
        return w;
    endfunction

    function automatic logic key_ok(input logic [DATA_W-1:0] w);
        return w[0] && (w[DATA_W-1 -: KEY_W] == RESTART_KEY);
    endfunction

endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic slow_tick,
    output logic tick_out
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick_out = run && slow_tick && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q <= '0;
        end else if (run && slow_tick) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    // R1: a step is never followed directly by another when the divider is above 1
    a_r1_step_spacing: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick_out) |=> !tick_out);

endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unf_flag,
    input  logic              err_flag,
    output mode_t             mode_q,
    output logic              mode_load,
    output logic [CNT_W-1:0]  load_value,
    output logic              restart_cmd,
    output logic              status_rd,
    output logic [DATA_W-1:0] rdata
);
    logic  locked_q;
    mode_t mode_new;

    assign mode_new    = unpack_mode(wdata);
    assign mode_load   = wr_en && (addr == REG_MODE) && !locked_q;
    assign load_value  = mode_new.reload;
    assign restart_cmd = wr_en && (addr == REG_CTRL) && key_ok(wdata);
    assign status_rd   = rd_en && (addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RESET;
            locked_q <= 1'b0;
        end else if (mode_load) begin
            mode_q   <= mode_new;
            locked_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == REG_MODE) begin
            rdata = pack_mode(mode_q);
        end else if (addr == REG_STAT) begin
            rdata[1:0] = {err_flag, unf_flag};
        end
    end

    // R5: once a mode word is taken, it never changes until reset
    a_r5_mode_locked: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> (locked_q && $stable(mode_q)));

endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int DIV = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic             mode_load,
    input  logic [CNT_W-1:0] load_value,
    input  logic             restart_cmd,
    input  logic             status_rd,
    input  logic             slow_tick,
    input  logic             dbg_halt,
    input  logic             idle_in,
    output logic             unf_q,
    output logic             err_q,
    output logic             fault_irq,
    output logic             reset_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             live, run, tick;
    logic             win_bad, restart_go, underflow_ev;

    assign live = !mode.disable_wd;
    assign run  = live && !(dbg_halt && mode.dbg_hold) && !(idle_in && mode.idle_hold);

    assign win_bad      = restart_cmd && live && (cnt_q > mode.delta);
    assign restart_go   = restart_cmd && live && !win_bad;
    assign underflow_ev = tick && (cnt_q <= CNT_W'(1)) && !restart_go && !mode_load;

    wdk_prescaler #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .clear     (mode_load || restart_go),
        .run       (run),
        .slow_tick (slow_tick),
        .tick_out  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= MODE_RESET.reload;
        end else if (mode_load) begin
            cnt_q <= load_value;
        end else if (restart_go) begin
            cnt_q <= mode.reload;
        end else if (tick) begin
            cnt_q <= (cnt_q <= CNT_W'(1)) ? mode.reload : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unf_q <= underflow_ev || (unf_q && !status_rd);
            err_q <= win_bad      || (err_q && !status_rd);
        end
    end

    assign fault_irq = mode.irq_en && (unf_q || err_q);
    assign reset_req = mode.rst_en && (unf_q || err_q);

    // R7: an early keyed restart leaves the error flag set
    a_r7_window_error: assert property (@(posedge clk) disable iff (rst)
        (restart_cmd && !mode.disable_wd && cnt_q > mode.delta) |=> err_q);

    // R8: stepping out of count 1 without a competing reload flags underflow
    a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q <= CNT_W'(1) && !restart_cmd && !mode_load) |=> unf_q);

    // R10: a status read with no new event leaves both flags clear
    a_r10_read_clear: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !tick && !restart_cmd) |=> (!unf_q && !err_q));

    // R11: a disabled watchdog holds its count and raises no flag
    a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode.disable_wd && !mode_load) |=> ($stable(cnt_q) && !$rose(unf_q) && !$rose(err_q)));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int PRESCALE = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              dbg_halt,
    input  logic              idle_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              fault_irq,
    output logic              reset_req
);
    mode_t            mode_q;
    logic             mode_load, restart_cmd, status_rd;
    logic [CNT_W-1:0] load_value;
    logic             unf_q, err_q;

    wdk_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .unf_flag    (unf_q),
        .err_flag    (err_q),
        .mode_q      (mode_q),
        .mode_load   (mode_load),
        .load_value  (load_value),
        .restart_cmd (restart_cmd),
        .status_rd   (status_rd),
        .rdata       (rdata)
    );

    wdk_core #(.DIV(PRESCALE)) u_core (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_q),
        .mode_load   (mode_load),
        .load_value  (load_value),
        .restart_cmd (restart_cmd),
        .status_rd   (status_rd),
        .slow_tick   (slow_tick),
        .dbg_halt    (dbg_halt),
        .idle_in     (idle_in),
        .unf_q       (unf_q),
        .err_q       (err_q),
        .fault_irq   (fault_irq),
        .reset_req   (reset_req)
    );

    // R9: a request output never rises without a flag behind it
    a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (fault_irq || reset_req) |-> (u_core.unf_q || u_core.err_q));

endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        idle_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fault_irq, reset_req;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wdog_keyed u_wdog_keyed (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
        .idle_in(idle_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fault_irq(fault_irq), .reset_req(reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; dbg_halt = 1'b0; idle_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        do_read(2'd1, d);
        check("R4 mode after reset", d, 32'h0FFF_2FFF);
        do_read(2'd2, d);
        check("R4 status after reset", d, 32'h0);
        check("R4 requests low", {30'b0, fault_irq, reset_req}, 32'h0);
    endtask

    task automatic t_basic_underflow();
        logic [31:0] d;
        do_reset();
        do_write(2'd1, 32'h0000_3003);
        edges(383);
        check("R1/R6 no underflow before 3*128", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R8/R9 irq at 3*128", {31'b0, fault_irq}, 32'h1);
        check("R9 reset request at 3*128", {31'b0, reset_req}, 32'h1);
        do_read(2'd2, d);
        check("R10 status shows underflow", d, 32'h1);
        check("R10 read clears flags", {30'b0, fault_irq, reset_req}, 32'h0);
        edges(382);
        check("R8 reloaded, not yet second underflow", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R8 second underflow after reload", {31'b0, fault_irq}, 32'h1);
    endtask

    task automatic t_window();
        logic [31:0] d;
        do_reset();
        do_write(2'd1, 32'h0005_100A);
        do_write(2'd0, 32'hA500_0001);
        check("R7 early restart raises irq", {31'b0, fault_irq}, 32'h1);
        do_read(2'd2, d);
        check("R7 status error bit", d, 32'h2);
        edges(638);
        do_write(2'd0, 32'hA500_0001);
        check("R7 in-window restart no error", {31'b0, fault_irq}, 32'h0);
        edges(1279);
        check("R2/R7 counter reloaded by restart", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R2/R7 underflow 10*128 after restart", {31'b0, fault_irq}, 32'h1);
    endtask

    task automatic t_bad_key();
        do_reset();
        do_write(2'd1, 32'h0000_2002);
        edges(99);
        do_write(2'd0, 32'h5A00_0001);
        do_write(2'd0, 32'hA500_0000);
        edges(154);
        check("R2 bad restarts ignored, no early request", {31'b0, reset_req}, 32'h0);
        edges(1);
        check("R2 underflow at original time", {31'b0, reset_req}, 32'h1);
        check("R9 irq stays low when disabled", {31'b0, fault_irq}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        do_write(2'd1, 32'h0000_1002);
        do_write(2'd1, 32'h0000_8001);
        do_read(2'd1, d);
        check("R5/R3 second mode write ignored", d, 32'h0000_1002);
        edges(253);
        check("R5 no early underflow", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R5 underflow from first mode", {31'b0, fault_irq}, 32'h1);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        do_reset();
        do_write(2'd1, 32'h0000_9001);
        edges(300);
        check("R11 disabled never underflows", {31'b0, fault_irq}, 32'h0);
        do_write(2'd0, 32'hA500_0001);
        edges(2);
        check("R11 restart while disabled no error", {31'b0, fault_irq}, 32'h0);
        do_read(2'd2, d);
        check("R11 status clear", d, 32'h0);
        do_read(2'd1, d);
        check("R3 mode readback", d, 32'h0000_9001);
    endtask

    task automatic t_halt();
        do_reset();
        @(negedge clk) dbg_halt = 1'b1;
        do_write(2'd1, 32'h1000_1001);
        edges(300);
        check("R12 debug halt stops count", {31'b0, fault_irq}, 32'h0);
        @(negedge clk) dbg_halt = 1'b0;
        edges(127);
        check("R12 count resumes after debug", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R12 underflow 128 after debug release", {31'b0, fault_irq}, 32'h1);

        do_reset();
        @(negedge clk) idle_in = 1'b1;
        do_write(2'd1, 32'h0000_1001);
        edges(127);
        check("R12 ungated idle has no effect (before)", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R12 ungated idle has no effect (due)", {31'b0, fault_irq}, 32'h1);

        do_reset();
        @(negedge clk) idle_in = 1'b1;
        do_write(2'd1, 32'h2000_1001);
        edges(200);
        check("R12 idle halt stops count", {31'b0, fault_irq}, 32'h0);
        @(negedge clk) idle_in = 1'b0;
        edges(127);
        check("R12 idle resume before due", {31'b0, fault_irq}, 32'h0);
        edges(1);
        check("R12 idle resume underflow", {31'b0, fault_irq}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_basic_underflow();
        t_window();
        t_bad_key();
        t_lock();
        t_disable();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule